// File: doc/BRIEF.md
# Prescaled Divider and Programmable Timer

This block keeps time for a processor core that reports its progress in bursts of machine cycles. On every update the core presents the count of machine cycles it has just finished. The block adds that count to a small remainder. Each time the remainder passes three, four cycles are taken away and one base tick is made, at most one per update. Base ticks drive two things. The first is a free-running 8-bit divider that advances once every sixteen base ticks. The second is a tick accumulator that paces a programmable 8-bit counter.

The control register enables the counter and selects its pace: 64, 1, 4 or 16 base ticks per increment. When the counter steps up from 0xFF it is loaded with the value held in the reload register, and an interrupt request pulse goes out. A byte-wide port with one address gives write access and combinational read access to all four registers.

Top module: `prog_timer`

## Requirements
- R1: After reset, all four registers read 0 and `ovf_irq` is low.
- R2: An update (`upd_valid` high) adds `upd_cycles` to the cycle remainder. If the sum exceeds 3, four is subtracted and exactly one base tick is made. Any excess is carried to later updates.
- R3: The divider (address 0) increments once every 16 base ticks and wraps from 0xFF to 0x00.
- R4: A write to address 0 clears the divider to 0 whatever the write data. If it coincides with an increment, the clear wins.
- R5: The counter (address 1) never steps while control bit 2 is clear.
- R6: The accumulator gains one per base tick and saturates at 64. On an update with control bit 2 set, the counter steps when the accumulator (including this update's tick) reaches the count chosen by control bits [1:0]: 0 needs 64, 1 needs 1, 2 needs 4, 3 needs 16. The accumulator is cleared when the counter steps.
- R7: A step from 0xFF loads the reload register (address 2) value into the counter. `ovf_irq` is then high for the following clock. The value loaded is the one held before any write made in the same clock.
- R8: Addresses are 0 divider, 1 counter, 2 reload, 3 control. Writes to 1 and 2 store the byte. Control keeps bits [2:0] and reads bits [7:3] as 0. A counter write in the clock of a step wins, and no request is raised.
- R9: With `upd_valid` low, no tick, step or request occurs, whatever `upd_cycles` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | An update is presented this clock |
| upd_cycles | input | CYC_W | Machine cycles executed in this update |
| reg_addr | input | 2 | Register select for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ovf_irq | output | 1 | One-clock overflow request |

## Verification
The hardest case to reach is the 64-tick pace near its limits. The accumulator saturates while the counter is disabled, so enabling it fires a step on the very next update. A divider wrap needs 4096 ticks. To reach both, the bench runs long stretches of four-cycle updates with the counter disabled, then switches the enable on. Same-clock collisions are also created on purpose: a counter write against an overflow, and a divider clear against an increment. A behavioural model compares every output on every clock.

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CYC_W   = 3,
  parameter int SUB_W   = 5,
  parameter int PRE_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [CYC_W-1:0] upd_cycles,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             ovf_irq
);
  localparam int MAX_THR = 64;
  localparam int TW = $clog2(MAX_THR) + 1;
  localparam int PW = $clog2(PRE_DIV);

  logic [SUB_W-1:0] sub_q;
  logic [PW-1:0]    pre_q;
  logic [TW-1:0]    acc_q;
  logic [7:0]       div_q, cnt_q, mod_q;
  logic [2:0]       ctl_q;
  logic             irq_q;

  logic [SUB_W-1:0] sub_sum;
  logic [TW-1:0]    acc_inc, thr;
  logic             tick, fire, wr_div, wr_cnt, wr_mod, wr_ctl;

  assign sub_sum = sub_q + SUB_W'(upd_cycles);
  assign tick    = upd_valid && (sub_sum > SUB_W'(3));
  assign acc_inc = (tick && acc_q != TW'(MAX_THR)) ? acc_q + TW'(1) : acc_q;

  always_comb begin
    case (ctl_q[1:0])
      2'd0:    thr = TW'(MAX_THR);
      2'd1:    thr = TW'(1);
      2'd2:    thr = TW'(4);
      default: thr = TW'(16);
    endcase
  end

  assign fire   = upd_valid && ctl_q[2] && (acc_inc >= thr);
  assign wr_div = reg_wr && reg_addr == 2'd0;
  assign wr_cnt = reg_wr && reg_addr == 2'd1;
  assign wr_mod = reg_wr && reg_addr == 2'd2;
  assign wr_ctl = reg_wr && reg_addr == 2'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q <= '0;
      pre_q <= '0;
      acc_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      mod_q <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (upd_valid) sub_q <= tick ? sub_sum - SUB_W'(4) : sub_sum;
      acc_q <= fire ? '0 : acc_inc;
      if (tick) pre_q <= (pre_q == PW'(PRE_DIV - 1)) ? '0 : pre_q + PW'(1);
      if (wr_div) div_q <= '0;
      else if (tick && pre_q == PW'(PRE_DIV - 1)) div_q <= div_q + 8'd1;
      if (wr_cnt) cnt_q <= reg_wdata;
      else if (fire) cnt_q <= (cnt_q == 8'hFF) ? mod_q : cnt_q + 8'd1;
      if (wr_mod) mod_q <= reg_wdata;
      if (wr_ctl) ctl_q <= reg_wdata[2:0];
      irq_q <= fire && !wr_cnt && cnt_q == 8'hFF;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = div_q;
      2'd1:    reg_rdata = cnt_q;
      2'd2:    reg_rdata = mod_q;
      default: reg_rdata = {5'd0, ctl_q};
    endcase
  end

  assign ovf_irq = irq_q;
endmodule

// File: rtl/prog_timer_checker.sv
module prog_timer_checker #(
  parameter int TW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_valid,
  input logic [1:0]    reg_addr,
  input logic          reg_wr,
  input logic [7:0]    reg_rdata,
  input logic          ovf_irq,
  input logic [7:0]    div_q,
  input logic [7:0]    cnt_q,
  input logic [7:0]    mod_q,
  input logic [2:0]    ctl_q,
  input logic [TW-1:0] acc_q
);
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> cnt_q == $past(mod_q));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[2] && !(reg_wr && reg_addr == 2'd1)) |=> cnt_q == $past(cnt_q));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !reg_wr) |=> ($stable(div_q) && $stable(cnt_q) && !ovf_irq));

  a_r4_div_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> div_q == 8'd0);

  a_r6_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= TW'(64));

  a_r8_ctl_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd3 |-> reg_rdata[7:3] == 5'd0);
endmodule

bind prog_timer prog_timer_checker #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rdata(reg_rdata), .ovf_irq(ovf_irq),
  .div_q(div_q), .cnt_q(cnt_q), .mod_q(mod_q), .ctl_q(ctl_q), .acc_q(acc_q)
);

// File: tb/prog_timer_bench.sv
module prog_timer_bench;
  localparam int CYC_W = 3;
  localparam time HALF = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_valid = 1'b0;
  logic [CYC_W-1:0] upd_cycles = '0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic ovf_irq;

  int checks = 0, fails = 0;
  string tag = "R1";

  int m_sub, m_pre, m_acc, m_div, m_cnt, m_mod, m_ctl;
  bit m_irq;

  always #HALF clk = ~clk;

  prog_timer u_prog_timer (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_cycles(upd_cycles),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_irq(ovf_irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sub = 0; m_pre = 0; m_acc = 0; m_div = 0;
      m_cnt = 0; m_mod = 0; m_ctl = 0; m_irq = 0;
    end else begin
      int need, nxt_cnt, nxt_mod, nxt_ctl, nxt_div;
      bit ticked, stepped;
      ticked = 0; stepped = 0;
      nxt_cnt = m_cnt; nxt_mod = m_mod; nxt_ctl = m_ctl; nxt_div = m_div;
      m_irq = 0;
      if (upd_valid) begin
        m_sub += int'(upd_cycles);
        if (m_sub > 3) begin m_sub -= 4; ticked = 1; end
      end
      if (ticked) begin
        if (m_acc < 64) m_acc++;
        m_pre++;
        if (m_pre == 16) begin m_pre = 0; nxt_div = (m_div + 1) % 256; end
      end
      case (m_ctl % 4)
        0: need = 64;
        1: need = 1;
        2: need = 4;
        default: need = 16;
      endcase
      if (upd_valid && m_ctl >= 4 && m_acc >= need) begin
        stepped = 1; m_acc = 0;
        if (m_cnt == 255) begin nxt_cnt = m_mod; m_irq = 1; end
        else nxt_cnt = m_cnt + 1;
      end
      if (reg_wr) begin
        case (reg_addr)
          2'd0: nxt_div = 0;
          2'd1: begin nxt_cnt = int'(reg_wdata); m_irq = 0; end
          2'd2: nxt_mod = int'(reg_wdata);
          default: nxt_ctl = int'(reg_wdata) % 8;
        endcase
      end
      m_div = nxt_div; m_cnt = nxt_cnt; m_mod = nxt_mod; m_ctl = nxt_ctl;
      if (stepped) begin end
    end
  end

  function automatic int exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_div;
      2'd1: return m_cnt;
      2'd2: return m_mod;
      default: return m_ctl;
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (int'(reg_rdata) != exp_rd(reg_addr)) begin
      fails++;
      $display("FAIL %s reg %0d rdata actual %02h expected %02h", tag, reg_addr, reg_rdata, exp_rd(reg_addr));
    end
    checks++;
    if (ovf_irq !== m_irq) begin
      fails++;
      $display("FAIL %s ovf_irq actual %0b expected %0b", tag, ovf_irq, m_irq);
    end
  endtask

  task automatic cyc(input bit v, input int c, input int a, input bit w, input int d);
    @(negedge clk);
    compare();
    upd_valid = v; upd_cycles = CYC_W'(c);
    reg_addr = 2'(a); reg_wr = w; reg_wdata = 8'(d);
  endtask

  task automatic wr(input int a, input int d);
    cyc(0, 0, a, 1, d);
  endtask

  task automatic run(input int n, input int c, input int a);
    for (int i = 0; i < n; i++) cyc(1, c, a, 0, 0);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tag = "R1";
    for (int i = 0; i < 4; i++) cyc(0, 0, i, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, 0, i, 0, 0);

    tag = "R8";
    wr(2, 8'hA5); wr(3, 8'hF8); wr(1, 8'h33);
    for (int i = 0; i < 4; i++) cyc(0, 0, i, 0, 0);
    tag = "R4";
    run(100, 4, 0);
    wr(0, 8'h5A);
    cyc(0, 0, 0, 0, 0);

    tag = "R7";
    wr(2, 8'hF0); wr(1, 8'hFC); wr(3, 5);
    run(40, 4, 1);

    tag = "R6";
    for (int code = 0; code < 4; code++) begin
      wr(3, 4 + code);
      for (int i = 0; i < 600; i++) cyc(1, $urandom_range(0, 5), 1, 0, 0);
    end

    tag = "R5";
    wr(3, 0);
    run(400, 4, 1);
    tag = "R6";
    wr(3, 4);
    run(3, 4, 1);

    tag = "R3";
    wr(3, 0);
    run(4200, 4, 0);

    tag = "R2";
    for (int i = 0; i < 300; i++) cyc(1, (i % 8 < 2) ? 7 : 1, i % 4, 0, 0);

    tag = "R9";
    wr(3, 5);
    for (int i = 0; i < 200; i++) cyc(0, $urandom_range(0, 7), i % 4, 0, 0);

    tag = "R8";
    wr(2, 8'h10); wr(1, 8'hFE);
    cyc(1, 4, 1, 0, 0);
    cyc(1, 4, 1, 1, 8'h77);
    run(3, 4, 1);
    tag = "R7";
    wr(1, 8'hFF);
    cyc(1, 4, 1, 1, 8'hFF);
    cyc(1, 4, 2, 1, 8'h22);
    run(3, 4, 1);
    tag = "R4";
    wr(3, 0);
    for (int i = 0; i < 64; i++) cyc(1, 4, 0, (i % 16) == 15, 8'hFF);

    tag = "R2";
    for (int i = 0; i < 20000; i++) begin
      bit w;
      int a;
      a = $urandom_range(0, 3);
      w = ($urandom_range(0, 63) == 0);
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 5), a, w,
          (a == 3) ? $urandom_range(4, 7) : $urandom_range(0, 255));
    end

    cyc(0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule